// File: doc/BRIEF.md
# Flash Multi-Word Program Command Sequencer

This block sits in the command interface of a NOR-style flash device. It watches bus write cycles. Each cycle is one `wr_en` strobe carrying an address and a data word. From these writes it recognises the multi-cycle program commands. Pair program covers two adjacent words in 16-bit mode, or two adjacent bytes in 8-bit mode. Quad program covers four adjacent words in 16-bit mode. It also recognises two single-cycle commands: buffer confirm and abort/reset.

During a pair or quad command, each write after the setup cycle delivers one address/data pair. The address bits that select a slot are the low bit for a pair and the two low bits for a quad. The data is stored in the slot those bits name, so the writes may come in any order. All remaining address bits must match the first write. A mismatch, a slot written twice, or a quad command in 8-bit mode ends the sequence with a one-cycle error flag and no start.

When the last slot is filled, the block gives a single start pulse. With it come the operation code, the group base address (slot bits cleared) and the collected data. While the program controller reports busy, every bus write is ignored.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, `start`, `seq_err` and `abort_out` are low.
- R2: In 16-bit mode (`byte_mode`=0), a write with data[7:0]=0x50 followed by two writes whose addresses differ only in bit 0, in either order, raises `start` for one cycle after the edge that samples the second write. With it, `start_op`=0, `start_addr` is the address with bit 0 cleared, and slot k of `start_data` (bits k*16+15..k*16) holds the data written to the address whose bit 0 is k. Slots 2 and 3 are zero.
- R3: In 16-bit mode, data[7:0]=0x56 followed by four writes whose addresses differ only in bits 1..0, in any order, starts with `start_op`=1. `start_addr` has bits 1..0 cleared, and slot k holds the data written to the address whose low two bits equal k.
- R4: In 8-bit mode (`byte_mode`=1), the 0x50 setup followed by two writes differing only in address bit 0 starts with `start_op`=2. Address and slots follow the R2 rule.
- R5: If a collecting write has upper address bits that differ from the first write of the sequence, or names a slot already filled, `seq_err` pulses for one cycle after that write. No start is given, and the next write is decoded as a new command.
- R6: A 0x56 setup in 8-bit mode raises `seq_err` for one cycle after that write, and the block stays idle.
- R7: When idle, a write with data[7:0]=0x29 raises `start` with `start_op`=3, `start_addr` equal to the write address, and all-zero `start_data`.
- R8: When idle, a write with data[7:0]=0xF0 raises `abort_out` for one cycle and does not start.
- R9: While `ctrl_busy` is high, writes have no effect: no start, no error, no abort, and no state is advanced.
- R10: Only data[7:0] is decoded in idle. Any other code is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One bus write cycle per high clock |
| wr_addr | input | ADDR_W | Write address (in 8-bit mode bit 0 is the byte select) |
| wr_data | input | DATA_W | Write data or command code |
| byte_mode | input | 1 | 1 = 8-bit bus mode, 0 = 16-bit |
| ctrl_busy | input | 1 | Program controller busy |
| start | output | 1 | One-cycle start pulse |
| start_op | output | 2 | 0 pair word, 1 quad word, 2 pair byte, 3 buffer confirm |
| start_addr | output | ADDR_W | Group base address |
| start_data | output | 4*DATA_W | Collected data, slot k at bits k*DATA_W upward |
| seq_err | output | 1 | One-cycle sequence error |
| abort_out | output | 1 | One-cycle abort/reset request |

## Verification
All three pulse outputs are registered. Each one is due exactly one clock after the edge that samples the write causing it. The bench drives each write on a falling edge and removes it on the next falling edge. It then checks the outputs at that point, half a cycle after the deciding edge and before any further write. One extra idle cycle is checked after each start to confirm the pulse lasts a single clock.

// File: rtl/flash_prog_seq.sv
module flash_prog_seq #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter logic [7:0] PAIR_CODE  = 8'h50,
  parameter logic [7:0] QUAD_CODE  = 8'h56,
  parameter logic [7:0] CONF_CODE  = 8'h29,
  parameter logic [7:0] ABORT_CODE = 8'hF0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                byte_mode,
  input  logic                ctrl_busy,
  output logic                start,
  output logic [1:0]          start_op,
  output logic [ADDR_W-1:0]   start_addr,
  output logic [4*DATA_W-1:0] start_data,
  output logic                seq_err,
  output logic                abort_out
);
  localparam logic [1:0] OP_PW = 2'd0, OP_QW = 2'd1, OP_PB = 2'd2, OP_CF = 2'd3;

  logic              collecting;
  logic [1:0]        op, cnt;
  logic [3:0]        filled;
  logic [ADDR_W-1:0] base;
  logic [DATA_W-1:0] slot [4];

  wire              accept = wr_en && !ctrl_busy;
  wire [ADDR_W-1:0] lmask  = (op == OP_QW) ? ADDR_W'(3) : ADDR_W'(1);
  wire [ADDR_W-1:0] hi     = wr_addr & ~lmask;
  wire [1:0]        idx    = wr_addr[1:0] & lmask[1:0];
  wire [1:0]        last   = (op == OP_QW) ? 2'd3 : 2'd1;
  wire              bad    = ((cnt != 2'd0) && (hi != base)) || filled[idx];

  assign start_data = {slot[3], slot[2], slot[1], slot[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      collecting <= 1'b0;
      op         <= OP_PW;
      cnt        <= 2'd0;
      filled     <= 4'd0;
      base       <= '0;
      start      <= 1'b0;
      start_op   <= OP_PW;
      start_addr <= '0;
      seq_err    <= 1'b0;
      abort_out  <= 1'b0;
      for (int i = 0; i < 4; i++) slot[i] <= '0;
    end else begin
      start     <= 1'b0;
      seq_err   <= 1'b0;
      abort_out <= 1'b0;
      if (accept) begin
        if (!collecting) begin
          if (wr_data[7:0] == PAIR_CODE || (wr_data[7:0] == QUAD_CODE && !byte_mode)) begin
            collecting <= 1'b1;
            op         <= (wr_data[7:0] == QUAD_CODE) ? OP_QW : (byte_mode ? OP_PB : OP_PW);
            cnt        <= 2'd0;
            filled     <= 4'd0;
            for (int i = 0; i < 4; i++) slot[i] <= '0;
          end else if (wr_data[7:0] == QUAD_CODE) begin
            seq_err <= 1'b1;
          end else if (wr_data[7:0] == CONF_CODE) begin
            start      <= 1'b1;
            start_op   <= OP_CF;
            start_addr <= wr_addr;
            for (int i = 0; i < 4; i++) slot[i] <= '0;
          end else if (wr_data[7:0] == ABORT_CODE) begin
            abort_out <= 1'b1;
          end
        end else if (bad) begin
          seq_err    <= 1'b1;
          collecting <= 1'b0;
        end else begin
          slot[idx]   <= wr_data;
          filled[idx] <= 1'b1;
          cnt         <= cnt + 2'd1;
          if (cnt == 2'd0) base <= hi;
          if (cnt == last) begin
            start      <= 1'b1;
            start_op   <= op;
            start_addr <= base;
            collecting <= 1'b0;
          end
        end
      end
    end
  end

  // R5
  no_start_with_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && seq_err));

  // R9
  busy_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_busy |=> !start && !seq_err && !abort_out);

  // R9
  no_write_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !start && !seq_err && !abort_out);

  // R3
  quad_base_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_op == OP_QW) |-> start_addr[1:0] == 2'b00);

  // R2
  pair_base_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (start_op == OP_PW || start_op == OP_PB)) |-> !start_addr[0]);

  // R8
  abort_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_out |-> !start && !seq_err);
endmodule

// File: tb/flash_prog_seq_tb.sv
`timescale 1ns/1ps
module flash_prog_seq_tb;
  logic        clk = 0, rst_n = 0, wr_en = 0, byte_mode = 0, ctrl_busy = 0;
  logic [11:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic        start, seq_err, abort_out;
  logic [1:0]  start_op;
  logic [11:0] start_addr;
  logic [63:0] start_data;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  flash_prog_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .byte_mode(byte_mode), .ctrl_busy(ctrl_busy), .start(start), .start_op(start_op),
    .start_addr(start_addr), .start_data(start_data), .seq_err(seq_err), .abort_out(abort_out));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic quiet(input string req);
    chk({req, " start"}, 64'(start), 0);
    chk({req, " err"}, 64'(seq_err), 0);
    chk({req, " abort"}, 64'(abort_out), 0);
  endtask

  task automatic started(input string req, input logic [1:0] op, input logic [11:0] a, input logic [63:0] d);
    chk({req, " start"}, 64'(start), 1);
    chk({req, " err"}, 64'(seq_err), 0);
    chk({req, " op"}, 64'(start_op), 64'(op));
    chk({req, " addr"}, 64'(start_addr), 64'(a));
    chk({req, " data"}, start_data, d);
    @(negedge clk);
    chk({req, " one-cycle"}, 64'(start), 0);
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [11:0] b;
    logic [63:0] e;
    repeat (3) @(negedge clk);
    quiet("R1");
    rst_n = 1;
    @(negedge clk);
    quiet("R1");

    // R2: pair word, both orders, several bases
    for (int bi = 0; bi < 6; bi++) begin
      for (int o = 0; o < 2; o++) begin
        b = 12'((bi * 1366) & 12'hFFE);
        wr(12'h555, 16'h0050);
        quiet("R2 setup");
        wr(b | 12'(o), 16'(16'h1000 + bi * 2 + o));
        quiet("R2 first");
        wr(b | 12'(1 - o), 16'(16'h1000 + bi * 2 + (1 - o)));
        e = 0;
        e[o*16 +: 16] = 16'(16'h1000 + bi * 2 + o);
        e[(1-o)*16 +: 16] = 16'(16'h1000 + bi * 2 + (1 - o));
        started("R2", 2'd0, b, e);
      end
    end

    // R3: quad word, all 24 orders
    for (int p0 = 0; p0 < 4; p0++)
      for (int p1 = 0; p1 < 4; p1++)
        for (int p2 = 0; p2 < 4; p2++)
          for (int p3 = 0; p3 < 4; p3++)
            if (p0 != p1 && p0 != p2 && p0 != p3 && p1 != p2 && p1 != p3 && p2 != p3) begin
              b = 12'((p0 * 64 + p1 * 16 + p2 * 4 + 12'h800) & 12'hFFC);
              wr(12'h0AA, 16'h0056);
              wr(b | 12'(p0), 16'(16'hA000 + p0));
              wr(b | 12'(p1), 16'(16'hA000 + p1));
              wr(b | 12'(p2), 16'(16'hA000 + p2));
              quiet("R3 partial");
              wr(b | 12'(p3), 16'(16'hA000 + p3));
              e = {16'hA003, 16'hA002, 16'hA001, 16'hA000};
              started("R3", 2'd1, b, e);
            end

    // R4: pair byte in 8-bit mode
    byte_mode = 1;
    for (int o = 0; o < 2; o++) begin
      wr(12'hAAA, 16'h0050);
      wr(12'h2F0 | 12'(o), 16'(16'h00C0 + o));
      wr(12'h2F0 | 12'(1 - o), 16'(16'h00C0 + 1 - o));
      started("R4", 2'd2, 12'h2F0, {32'h0, 16'h00C1, 16'h00C0});
    end

    // R6: quad in 8-bit mode
    wr(12'h0AA, 16'h0056);
    chk("R6 err", 64'(seq_err), 1);
    chk("R6 start", 64'(start), 0);
    @(negedge clk);
    chk("R6 one-cycle", 64'(seq_err), 0);
    wr(12'h100, 16'h0050);
    wr(12'h101, 16'h0022);
    wr(12'h100, 16'h0011);
    started("R6 idle after", 2'd2, 12'h100, {32'h0, 16'h0022, 16'h0011});
    byte_mode = 0;

    // R5: upper-bit mismatch
    wr(12'h555, 16'h0050);
    wr(12'h040, 16'h1111);
    wr(12'h051, 16'h2222);
    chk("R5 err mismatch", 64'(seq_err), 1);
    chk("R5 no start", 64'(start), 0);
    // R5: duplicate slot in quad
    wr(12'h555, 16'h0056);
    wr(12'h200, 16'h1);
    wr(12'h201, 16'h2);
    wr(12'h201, 16'h3);
    chk("R5 err dup", 64'(seq_err), 1);
    chk("R5 no start dup", 64'(start), 0);
    wr(12'h0AB, 16'h0029);
    started("R5 idle after", 2'd3, 12'h0AB, 64'h0);

    // R7 confirm
    wr(12'h123, 16'h0029);
    started("R7", 2'd3, 12'h123, 64'h0);

    // R8 abort
    wr(12'h777, 16'h00F0);
    chk("R8 abort", 64'(abort_out), 1);
    chk("R8 start", 64'(start), 0);
    @(negedge clk);
    chk("R8 one-cycle", 64'(abort_out), 0);

    // R9 busy
    ctrl_busy = 1;
    wr(12'h555, 16'h0050);
    wr(12'h300, 16'h0029);
    quiet("R9 busy");
    wr(12'h301, 16'h00F0);
    quiet("R9 busy");
    ctrl_busy = 0;
    wr(12'h300, 16'h4444);
    quiet("R9 not collecting");
    wr(12'h301, 16'h5555);
    quiet("R9 not collecting");

    // R10 code decode
    wr(12'h010, 16'h0077);
    quiet("R10 unknown");
    wr(12'h3AB, 16'hAB29);
    started("R10 high byte ignored", 2'd3, 12'h3AB, 64'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule